// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block sits between the register port of an SPI controller and its serial engine. It owns two FIFOs. The transmit FIFO is filled by software writes and drained by the engine. The receive FIFO is filled by the engine and drained by software reads. It reports each fill level, compares the levels with programmable thresholds, and keeps sticky error flags for pushes into a full FIFO and reads from an empty one. It folds all of this into a status word and a raw interrupt word. The raw word is masked and reduced to one interrupt line.

Software reaches the block through a word-addressed port with a 4-bit address and 16-bit data. Read data is combinational from the current state. A read of the receive data address pops one entry on the clock edge at which it is presented. The threshold registers keep only as many bits as address the FIFO, so writing an oversized value and reading it back reveals the depth. The engine side has a pop strobe with the transmit head word, a push strobe with receive data, and a busy input.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After reset both FIFOs are empty, all sticky flags are clear, the mask is zero, irq_o is low, the status word reads 0x0C and the raw word reads 0x01.
- R2: Status bits: [0] engine busy, [1] transmit full, [2] transmit empty, [3] receive empty, [4] receive full.
- R3: A write to address 0 pushes one word into the transmit FIFO. The engine sees the oldest word on eng_tx_data_o and removes it with eng_tx_pop_i, in first-in first-out order.
- R4: A write to address 0 while the transmit FIFO is full drops the word, leaves the level at DEPTH and sets raw bit 1.
- R5: eng_rx_push_i stores a word in the receive FIFO. A read of address 1 returns the oldest word and pops it, in first-in first-out order.
- R6: An engine push while the receive FIFO is full drops the word and sets raw bit 3.
- R7: A read of address 1 while the receive FIFO is empty returns zero and sets raw bit 2.
- R8: The thresholds at addresses 2 (transmit) and 3 (receive) keep only the low log2(DEPTH) bits of the written value. With DEPTH 8, a write of 9 reads back 1.
- R9: Raw bit 0 is high while the transmit level is at or below its threshold. Raw bit 4 is high while the receive level exceeds its threshold. Both follow the levels and are never latched.
- R10: A write to the clear register (address 10) clears a sticky flag when its own bit or bit 0 is set: bit 1 clears raw bit 2, bit 2 clears raw bit 3, bit 3 clears raw bit 1. Sticky flags otherwise hold, and raw bits 0 and 4 are unaffected.
- R11: Address 7 holds the 5-bit mask. Address 8 reads raw AND mask, and irq_o is high when any masked bit is set.
- R12: Address 4 reads the transmit level, address 5 the receive level, address 6 the status word and address 9 the raw word. The levels never exceed DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (needed for pop side effects) |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | RW | Write data |
| reg_rdata_o | output | RW | Read data for the current address |
| eng_busy_i | input | 1 | Serial engine busy |
| eng_tx_pop_i | input | 1 | Engine takes the transmit head word |
| eng_tx_data_o | output | DW | Transmit head word, zero when empty |
| eng_rx_push_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | DW | Received word |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest state to reach is the one where a sticky error flag and a level-driven source are high together, and a global clear has to drop the first while the second stays. The receive FIFO is filled past its threshold and then pushed once more while full, so that raw bits 3 and 4 are both set. A per-source clear then shows irq_o falling under a mask that selects only bit 3. Before that, the transmit FIFO is drained to the level where the threshold source rises, and a clear-all is written to show that the level source survives it.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [3:0] {
    A_TXD  = 4'd0,
    A_RXD  = 4'd1,
    A_TXTH = 4'd2,
    A_RXTH = 4'd3,
    A_TXLV = 4'd4,
    A_RXLV = 4'd5,
    A_STAT = 4'd6,
    A_MASK = 4'd7,
    A_MIS  = 4'd8,
    A_RIS  = 4'd9,
    A_CLR  = 4'd10
  } reg_addr_e;

  localparam int NSRC = 5;
  localparam int NCLR = 4;

  // status bits
  localparam int ST_BUSY = 0;
  localparam int ST_TXF  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_RXE  = 3;
  localparam int ST_RXF  = 4;

  // interrupt sources
  localparam int IR_TXTH = 0;
  localparam int IR_TXO  = 1;
  localparam int IR_RXU  = 2;
  localparam int IR_RXO  = 3;
  localparam int IR_RXTH = 4;

  // clear bits
  localparam int CL_ALL = 0;
  localparam int CL_RXU = 1;
  localparam int CL_RXO = 2;
  localparam int CL_TXO = 3;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign level_o = cnt_q;
  assign rdata_o = empty_o ? '0 : mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
  import spi_fifo_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_lvl_i,
  input  logic            rx_lvl_i,
  input  logic            set_txo_i,
  input  logic            set_rxu_i,
  input  logic            set_rxo_i,
  input  logic            clr_we_i,
  input  logic [NCLR-1:0] clr_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] raw_o,
  output logic [NSRC-1:0] mis_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic txo_q, rxu_q, rxo_q;
  logic clr_txo, clr_rxu, clr_rxo;

  assign clr_txo = clr_we_i && (clr_i[CL_ALL] || clr_i[CL_TXO]);
  assign clr_rxu = clr_we_i && (clr_i[CL_ALL] || clr_i[CL_RXU]);
  assign clr_rxo = clr_we_i && (clr_i[CL_ALL] || clr_i[CL_RXO]);

  // a new event in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txo_q  <= 1'b0;
      rxu_q  <= 1'b0;
      rxo_q  <= 1'b0;
      mask_o <= '0;
    end else begin
      txo_q <= set_txo_i || (txo_q && !clr_txo);
      rxu_q <= set_rxu_i || (rxu_q && !clr_rxu);
      rxo_q <= set_rxo_i || (rxo_q && !clr_rxo);
      if (mask_we_i) mask_o <= mask_i;
    end
  end

  always_comb begin
    raw_o          = '0;
    raw_o[IR_TXTH] = tx_lvl_i;
    raw_o[IR_TXO]  = txo_q;
    raw_o[IR_RXU]  = rxu_q;
    raw_o[IR_RXO]  = rxo_q;
    raw_o[IR_RXTH] = rx_lvl_i;
  end

  assign mis_o = raw_o & mask_o;
  assign irq_o = |mis_o;
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int RW    = 16,
  parameter int DEPTH = 8,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  input  logic          eng_busy_i,
  input  logic          eng_tx_pop_i,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  output logic          irq_o
);
  logic [LW-1:0]   tx_lvl, rx_lvl;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0]   rx_head;
  logic [TW-1:0]   tx_thr_q, rx_thr_q;
  logic            wr_txd, rd_rxd, wr_clr, wr_mask;
  logic [NSRC-1:0] raw, mis, mask;
  logic [NSRC-1:0] stat;

  assign wr_txd  = reg_we_i && (reg_addr_i == A_TXD);
  assign rd_rxd  = reg_re_i && (reg_addr_i == A_RXD);
  assign wr_clr  = reg_we_i && (reg_addr_i == A_CLR);
  assign wr_mask = reg_we_i && (reg_addr_i == A_MASK);

  spi_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_txd),
    .wdata_i (reg_wdata_i[DW-1:0]),
    .pop_i   (eng_tx_pop_i),
    .rdata_o (eng_tx_data_o),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rd_rxd),
    .rdata_o (rx_head),
    .level_o (rx_lvl),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  // thresholds keep only the bits that address the FIFO
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_TXTH) tx_thr_q <= reg_wdata_i[TW-1:0];
      if (reg_addr_i == A_RXTH) rx_thr_q <= reg_wdata_i[TW-1:0];
    end
  end

  spi_irq_flags i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_lvl_i  (tx_lvl <= LW'(tx_thr_q)),
    .rx_lvl_i  (rx_lvl > LW'(rx_thr_q)),
    .set_txo_i (wr_txd && tx_full),
    .set_rxu_i (rd_rxd && rx_empty),
    .set_rxo_i (eng_rx_push_i && rx_full),
    .clr_we_i  (wr_clr),
    .clr_i     (reg_wdata_i[NCLR-1:0]),
    .mask_we_i (wr_mask),
    .mask_i    (reg_wdata_i[NSRC-1:0]),
    .raw_o     (raw),
    .mis_o     (mis),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    stat          = '0;
    stat[ST_BUSY] = eng_busy_i;
    stat[ST_TXF]  = tx_full;
    stat[ST_TXE]  = tx_empty;
    stat[ST_RXE]  = rx_empty;
    stat[ST_RXF]  = rx_full;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_RXD:   reg_rdata_o = RW'(rx_head);
      A_TXTH:  reg_rdata_o = RW'(tx_thr_q);
      A_RXTH:  reg_rdata_o = RW'(rx_thr_q);
      A_TXLV:  reg_rdata_o = RW'(tx_lvl);
      A_RXLV:  reg_rdata_o = RW'(rx_lvl);
      A_STAT:  reg_rdata_o = RW'(stat);
      A_MASK:  reg_rdata_o = RW'(mask);
      A_MIS:   reg_rdata_o = RW'(mis);
      A_RIS:   reg_rdata_o = RW'(raw);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_txd_i,
  input logic          tx_pop_i,
  input logic          rd_rxd_i,
  input logic          rx_push_i,
  input logic          clr_we_i,
  input logic [3:0]    clr_i,
  input logic [LW-1:0] tx_lvl_i,
  input logic [LW-1:0] rx_lvl_i,
  input logic [4:0]    raw_i,
  input logic [4:0]    stat_i
);
  a_r4_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txd_i && tx_lvl_i == LW'(DEPTH) && !tx_pop_i) |=> (tx_lvl_i == LW'(DEPTH)));

  a_r4_txo_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txd_i && tx_lvl_i == LW'(DEPTH)) |=> raw_i[1]);

  a_r6_rxo_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_lvl_i == LW'(DEPTH)) |=> raw_i[3]);

  a_r7_rxu_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rxd_i && rx_lvl_i == '0) |=> raw_i[2]);

  a_r10_txo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i[1] && !(clr_we_i && (clr_i[0] || clr_i[3]))) |=> raw_i[1]);

  a_r10_rxo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i[3] && !(clr_we_i && (clr_i[0] || clr_i[2]))) |=> raw_i[3]);

  a_r2_full_empty_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat_i[1] && stat_i[2]) && !(stat_i[3] && stat_i[4]));

  a_r12_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lvl_i <= LW'(DEPTH)) && (rx_lvl_i <= LW'(DEPTH)));
endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_txd_i  (wr_txd),
  .tx_pop_i  (eng_tx_pop_i),
  .rd_rxd_i  (rd_rxd),
  .rx_push_i (eng_rx_push_i),
  .clr_we_i  (wr_clr),
  .clr_i     (reg_wdata_i[3:0]),
  .tx_lvl_i  (tx_lvl),
  .rx_lvl_i  (rx_lvl),
  .raw_i     (raw),
  .stat_i    (stat)
);

// File: tb/test_spi_fifo_irq_ctrl.sv
module test_spi_fifo_irq_ctrl;
  import spi_fifo_pkg::*;

  localparam int DW = 16;
  localparam int RW = 16;
  localparam int DEPTH = 8;
  localparam int NV = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [DW-1:0] eng_tx_data, eng_rx_data = '0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_ctrl #(.DW(DW), .RW(RW), .DEPTH(DEPTH)) i_spi_fifo_irq_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .reg_we_i      (reg_we),
    .reg_re_i      (reg_re),
    .reg_addr_i    (reg_addr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .eng_busy_i    (eng_busy),
    .eng_tx_pop_i  (eng_tx_pop),
    .eng_tx_data_o (eng_tx_data),
    .eng_rx_push_i (eng_rx_push),
    .eng_rx_data_i (eng_rx_data),
    .irq_o         (irq)
  );

  // {req[40:37], read[36], addr[35:32], wdata[31:16], expect[15:0]}
  localparam logic [40:0] VEC [NV] = '{
    {4'd8,  1'b0, 4'd2,  16'd9,      16'h0000},  // R8 oversize threshold
    {4'd8,  1'b1, 4'd2,  16'd0,      16'h0001},
    {4'd8,  1'b0, 4'd2,  16'd3,      16'h0000},
    {4'd8,  1'b1, 4'd2,  16'd0,      16'h0003},
    {4'd3,  1'b0, 4'd0,  16'h1111,   16'h0000},  // R3 fill
    {4'd3,  1'b0, 4'd0,  16'h2222,   16'h0000},
    {4'd3,  1'b0, 4'd0,  16'h3333,   16'h0000},
    {4'd3,  1'b0, 4'd0,  16'h4444,   16'h0000},
    {4'd12, 1'b1, 4'd4,  16'd0,      16'h0004},  // R12 level
    {4'd9,  1'b1, 4'd9,  16'd0,      16'h0000},  // R9 level above thr
    {4'd3,  1'b0, 4'd0,  16'h5555,   16'h0000},
    {4'd3,  1'b0, 4'd0,  16'h6666,   16'h0000},
    {4'd3,  1'b0, 4'd0,  16'h7777,   16'h0000},
    {4'd3,  1'b0, 4'd0,  16'h8888,   16'h0000},
    {4'd2,  1'b1, 4'd6,  16'd0,      16'h000A},  // R2 tx full
    {4'd4,  1'b0, 4'd0,  16'h9999,   16'h0000},  // R4 overflow
    {4'd4,  1'b1, 4'd4,  16'd0,      16'h0008},
    {4'd4,  1'b1, 4'd9,  16'd0,      16'h0002},
    {4'd7,  1'b1, 4'd1,  16'd0,      16'h0000},  // R7 underflow read
    {4'd7,  1'b1, 4'd9,  16'd0,      16'h0006},
    {4'd11, 1'b0, 4'd7,  16'h001F,   16'h0000},  // R11 mask
    {4'd11, 1'b1, 4'd8,  16'd0,      16'h0006},
    {4'd10, 1'b0, 4'd10, 16'h0008,   16'h0000},  // R10 clear txo
    {4'd10, 1'b1, 4'd9,  16'd0,      16'h0004},
    {4'd10, 1'b0, 4'd10, 16'h0001,   16'h0000},  // R10 clear all
    {4'd10, 1'b1, 4'd9,  16'd0,      16'h0000},
    {4'd11, 1'b1, 4'd8,  16'd0,      16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [RW-1:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic eng_push(input logic [DW-1:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, v); check("R1 status", 32'(v), 32'h0C);
    rd(A_RIS,  v); check("R1 raw", 32'(v), 32'h01);
    rd(A_MASK, v); check("R1 mask", 32'(v), 32'h00);
    rd(A_TXLV, v); check("R1 tx level", 32'(v), 32'h00);
    #1 check("R1 irq", 32'(irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36]) begin
        rd(VEC[i][35:32], v);
        check($sformatf("R%0d step %0d", VEC[i][40:37], i), 32'(v), 32'(VEC[i][15:0]));
      end else begin
        wr(VEC[i][35:32], VEC[i][31:16]);
      end
    end
    #1 check("R11 irq low, no masked bit", 32'(irq), 32'h0);

    // R3 engine drains transmit FIFO in order
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      #1 check("R3 tx order", 32'(eng_tx_data), 32'((i + 1) * 16'h1111));
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
    end
    rd(A_TXLV, v); check("R12 tx level drained", 32'(v), 32'h0);
    rd(A_RIS,  v); check("R9 tx at threshold", 32'(v), 32'h01);
    #1 check("R11 irq from level source", 32'(irq), 32'h1);

    rd(A_STAT, v); check("R2 idle", 32'(v), 32'h0C);
    eng_busy = 1'b1;
    rd(A_STAT, v); check("R2 busy", 32'(v), 32'h0D);

    wr(A_CLR, 16'h000F);
    rd(A_RIS, v); check("R10 level source survives clear", 32'(v), 32'h01);

    // receive path
    wr(A_RXTH, 16'd2);
    eng_push(16'hA000);
    eng_push(16'hA001);
    rd(A_RIS, v); check("R9 rx at threshold", 32'(v), 32'h01);
    eng_push(16'hA002);
    rd(A_RIS, v); check("R9 rx above threshold", 32'(v), 32'h11);
    rd(A_RXLV, v); check("R12 rx level", 32'(v), 32'h3);
    for (int i = 3; i < DEPTH; i++) eng_push(16'hA000 + 16'(i));
    rd(A_STAT, v); check("R2 rx full", 32'(v), 32'h15);
    eng_push(16'hEEEE);
    rd(A_RIS, v); check("R6 rx overflow", 32'(v), 32'h19);
    rd(A_RXLV, v); check("R6 level held", 32'(v), 32'h8);

    wr(A_MASK, 16'h0008);
    #1 check("R11 irq masked overflow", 32'(irq), 32'h1);
    wr(A_CLR, 16'h0004);
    rd(A_RIS, v); check("R10 clear rx overflow", 32'(v), 32'h11);
    #1 check("R11 irq after clear", 32'(irq), 32'h0);

    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, v); check("R5 rx order", 32'(v), 32'(16'hA000 + 16'(i)));
    end
    rd(A_RXLV, v); check("R5 rx drained", 32'(v), 32'h0);
    rd(A_RIS, v); check("R7 no underflow on drain", 32'(v), 32'h01);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule